// File: doc/BRIEF.md
# Fixed-Priority Interrupt Controller

This block collects three interrupt sources for a small 8-bit core: two active-low external pins and a one-cycle overflow pulse from a 16-bit timer. Each external pin can be set to edge mode, where a synchronized falling edge latches a flag, or to level mode, where the flag follows the synchronized pin. Timer overflow sets a timer flag. A shared 8-bit control/status register holds the flags, the pin type bits and the timer configuration bits. The timer uses the configuration bits, but the timer itself is not part of this block.

A 4-bit enable register holds one enable per source and a global enable. When a flag and its enables are all set and no interrupt is in service, the block raises a request toward the CPU. It also presents the vector address of the winning source, using a fixed single-level priority. When the CPU acknowledges, the edge flag or timer flag of the granted source is cleared and the block enters the in-service state. It issues no new vector until a return strobe arrives. A separate wake output tells an idle core that an enabled interrupt is pending, whether or not one is in service.

Top module: `irqPrioCtrl`

## Requirements
- R1: After reset the control register reads 0x00, the enable register reads 0x0, `irqReq` and `idleWake` are 0 and `irqVector` is 0x000.
- R2: Control register bit layout, MSB first: bit 7 gate, bit 6 counter/timer select, bit 5 timer flag, bit 4 run, bit 3 pin-0 flag, bit 2 pin-0 type, bit 1 pin-1 flag, bit 0 pin-1 type. A write stores all bits, except a flag whose pin is in level mode. `tmrGate`, `tmrCntSel` and `tmrRun` show bits 7, 6 and 4.
- R3: In edge mode (type bit 1), a falling edge on the pin sets its flag. The flag is readable at the third rising clock edge after the pin changes. A rising edge sets nothing, and a software write can set or clear the flag.
- R4: In level mode (type bit 0), the flag reads 1 while the pin is low and 0 while it is high, with the same three-edge latency. A software write to that flag has no effect.
- R5: A one-cycle `timerOvf` pulse sets the timer flag (bit 5) at the next rising edge.
- R6: Enable register bits: [0] pin 0, [1] timer, [2] pin 1, [3] global. A source can request only when its flag, its own enable and the global enable are all 1.
- R7: When several sources request at once, pin 0 wins over the timer, and the timer wins over pin 1. The vectors are 0x003 for pin 0, 0x00B for the timer and 0x013 for pin 1. `irqVector` is 0x000 when there is no request.
- R8: `irqAck` while `irqReq` is high clears only the granted source's flag, and only if that source is in edge mode or is the timer. A level-mode flag keeps following its pin.
- R9: After an acknowledge, `irqReq` stays 0 until `irqRet` is pulsed. After that, the pending requests are presented again.
- R10: `idleWake` is 1 exactly when the global enable is 1 and at least one source has both its flag and its own enable set. The in-service state does not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| extPin0N | input | 1 | External interrupt pin 0, active low, asynchronous |
| extPin1N | input | 1 | External interrupt pin 1, active low, asynchronous |
| timerOvf | input | 1 | One-cycle timer overflow pulse |
| ctlWrEn | input | 1 | Control register write strobe |
| ctlWrData | input | 8 | Control register write data |
| ctlRdData | output | 8 | Control register contents |
| enWrEn | input | 1 | Enable register write strobe |
| enWrData | input | 4 | Enable register write data |
| enRdData | output | 4 | Enable register contents |
| irqAck | input | 1 | CPU takes the presented vector |
| irqRet | input | 1 | Return from interrupt, ends in-service |
| irqReq | output | 1 | Interrupt request to the CPU |
| irqVector | output | 10 | Vector address of the winning source |
| idleWake | output | 1 | Enabled interrupt pending, wakes an idle core |
| tmrGate | output | 1 | Gate configuration bit to the timer |
| tmrCntSel | output | 1 | Counter/timer select bit to the timer |
| tmrRun | output | 1 | Run bit to the timer |

## Verification
The bench writes random flag and enable patterns and compares the request, the vector and the wake output with a priority model. A design with the priority order swapped, or with a vector offset off by one stride, would show the wrong address here. Directed cases drive each pin in both modes. A detector that reacts to rising edges, or a level flag that software could overwrite, would show a flag that differs from the pin. Acknowledge cases check two things: that only the winning flag clears while a level-mode flag survives, and that no vector is reissued before the return strobe. A design that leaves the in-service state on its own, or clears every flag at once, fails these cases.

// File: rtl/irqPrioPkg.sv
package irqPrioPkg;
  localparam int NUM_SRC = 3;
  // control register bit positions (software decodes these)
  localparam int CTL_GATE = 7;
  localparam int CTL_CSEL = 6;
  localparam int CTL_TF   = 5;
  localparam int CTL_RUN  = 4;
  localparam int CTL_F0   = 3;
  localparam int CTL_T0   = 2;
  localparam int CTL_F1   = 1;
  localparam int CTL_T1   = 0;
  // enable register bit positions
  localparam int EN_GLOBAL = NUM_SRC;

  // per-source clear strobes from control to datapath, index = priority rank
  typedef struct packed {
    logic [NUM_SRC-1:0] clrFlag;
  } ackStrobe_t;
endpackage

// File: rtl/irqFlagPath.sv
module irqFlagPath
  import irqPrioPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CTL_W = 8,
  parameter int EN_W = NUM_SRC + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             extPin0N,
  input  logic             extPin1N,
  input  logic             timerOvf,
  input  logic             ctlWrEn,
  input  logic [CTL_W-1:0] ctlWrData,
  input  logic             enWrEn,
  input  logic [EN_W-1:0]  enWrData,
  input  ackStrobe_t       strobes,
  output logic [CTL_W-1:0] ctlQ,
  output logic [EN_W-1:0]  enQ,
  output logic [NUM_SRC-1:0] srcFlags
);
  localparam int NUM_PIN = 2;

  logic [NUM_PIN-1:0] pinRaw;
  logic [NUM_PIN-1:0] pinSync;
  logic [NUM_PIN-1:0] pinPrev;
  logic [NUM_PIN-1:0] pinFall;

  assign pinRaw = {extPin1N, extPin0N};

  genvar g;
  generate
    for (g = 0; g < NUM_PIN; g++) begin : g_sync
      logic [SYNC_STAGES-1:0] chainQ;
      always_ff @(posedge clk) begin
        if (!rst_n) chainQ <= '1;
        else        chainQ <= {chainQ[SYNC_STAGES-2:0], pinRaw[g]};
      end
      assign pinSync[g] = chainQ[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) pinPrev <= '1;
    else        pinPrev <= pinSync;
  end

  assign pinFall = pinPrev & ~pinSync;

  logic [CTL_W-1:0] ctlNext;
  always_comb begin
    ctlNext = ctlQ;
    if (ctlWrEn) ctlNext = ctlWrData;
    // timer flag: acknowledge clears, a new overflow wins
    if (strobes.clrFlag[1]) ctlNext[CTL_TF] = 1'b0;
    if (timerOvf)           ctlNext[CTL_TF] = 1'b1;
    // pin 0
    if (ctlNext[CTL_T0]) begin
      if (strobes.clrFlag[0]) ctlNext[CTL_F0] = 1'b0;
      if (pinFall[0])         ctlNext[CTL_F0] = 1'b1;
    end else begin
      ctlNext[CTL_F0] = ~pinSync[0];
    end
    // pin 1
    if (ctlNext[CTL_T1]) begin
      if (strobes.clrFlag[2]) ctlNext[CTL_F1] = 1'b0;
      if (pinFall[1])         ctlNext[CTL_F1] = 1'b1;
    end else begin
      ctlNext[CTL_F1] = ~pinSync[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctlQ <= '0;
      enQ  <= '0;
    end else begin
      ctlQ <= ctlNext;
      if (enWrEn) enQ <= enWrData;
    end
  end

  assign srcFlags = {ctlQ[CTL_F1], ctlQ[CTL_TF], ctlQ[CTL_F0]};

  p_tf_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    timerOvf |=> ctlQ[CTL_TF]);

  p_ack_clears_tf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.clrFlag[1] && !timerOvf && !ctlWrEn) |=> !ctlQ[CTL_TF]);

  p_edge_flag_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctlQ[CTL_T0] && ctlQ[CTL_F0] && !ctlWrEn && !strobes.clrFlag[0]) |=> ctlQ[CTL_F0]);

  p_en_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !enWrEn |=> $stable(enQ));
endmodule

// File: rtl/irqPrioCtrl_ctl.sv
module irqPrioCtrl_ctl
  import irqPrioPkg::*;
#(
  parameter int VEC_W = 10,
  parameter int VEC_BASE = 3,
  parameter int VEC_STRIDE = 8,
  parameter int EN_W = NUM_SRC + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] srcFlags,
  input  logic [EN_W-1:0]    enQ,
  input  logic               irqAck,
  input  logic               irqRet,
  output ackStrobe_t         strobes,
  output logic               irqReq,
  output logic [VEC_W-1:0]   irqVector,
  output logic               idleWake
);
  logic [NUM_SRC-1:0] activeSrc;
  logic [NUM_SRC-1:0] winOneHot;
  logic [VEC_W-1:0]   winVec;
  logic               inService;
  logic               grant;

  assign activeSrc = srcFlags & enQ[NUM_SRC-1:0] & {NUM_SRC{enQ[EN_GLOBAL]}};

  // rank 0 is highest priority
  always_comb begin
    winOneHot = '0;
    winVec    = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (activeSrc[i]) begin
        winOneHot = '0;
        winOneHot[i] = 1'b1;
        winVec = VEC_W'(VEC_BASE + i * VEC_STRIDE);
      end
    end
  end

  assign irqReq    = (|activeSrc) && !inService;
  assign irqVector = irqReq ? winVec : '0;
  assign idleWake  = |activeSrc;
  assign grant     = irqAck && irqReq;
  assign strobes.clrFlag = grant ? winOneHot : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)      inService <= 1'b0;
    else if (grant)  inService <= 1'b1;
    else if (irqRet) inService <= 1'b0;
  end

  p_ack_enters_service_r9: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> !irqReq);

  p_stay_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!irqReq && !irqRet && $past(grant)) |=> !irqReq);

  p_vec_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irqReq |-> (irqVector != '0));

  p_one_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobes.clrFlag));

  p_wake_global_r10: assert property (@(posedge clk) disable iff (!rst_n)
    idleWake |-> enQ[EN_GLOBAL]);
endmodule

// File: rtl/irqPrioCtrl.sv
module irqPrioCtrl
  import irqPrioPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int VEC_W = 10,
  parameter int VEC_BASE = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             extPin0N,
  input  logic             extPin1N,
  input  logic             timerOvf,
  input  logic             ctlWrEn,
  input  logic [7:0]       ctlWrData,
  output logic [7:0]       ctlRdData,
  input  logic             enWrEn,
  input  logic [3:0]       enWrData,
  output logic [3:0]       enRdData,
  input  logic             irqAck,
  input  logic             irqRet,
  output logic             irqReq,
  output logic [VEC_W-1:0] irqVector,
  output logic             idleWake,
  output logic             tmrGate,
  output logic             tmrCntSel,
  output logic             tmrRun
);
  localparam int CTL_W = 8;
  localparam int EN_W = NUM_SRC + 1;

  ackStrobe_t         strobes;
  logic [CTL_W-1:0]   ctlQ;
  logic [EN_W-1:0]    enQ;
  logic [NUM_SRC-1:0] srcFlags;

  irqFlagPath #(.SYNC_STAGES(SYNC_STAGES), .CTL_W(CTL_W), .EN_W(EN_W)) path_i (
    .clk(clk), .rst_n(rst_n), .extPin0N(extPin0N), .extPin1N(extPin1N),
    .timerOvf(timerOvf), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .enWrEn(enWrEn), .enWrData(enWrData), .strobes(strobes),
    .ctlQ(ctlQ), .enQ(enQ), .srcFlags(srcFlags)
  );

  irqPrioCtrl_ctl #(.VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE),
                    .EN_W(EN_W)) ctl_i (
    .clk(clk), .rst_n(rst_n), .srcFlags(srcFlags), .enQ(enQ),
    .irqAck(irqAck), .irqRet(irqRet), .strobes(strobes),
    .irqReq(irqReq), .irqVector(irqVector), .idleWake(idleWake)
  );

  assign ctlRdData = ctlQ;
  assign enRdData  = enQ;
  assign tmrGate   = ctlQ[CTL_GATE];
  assign tmrCntSel = ctlQ[CTL_CSEL];
  assign tmrRun    = ctlQ[CTL_RUN];
endmodule

// File: tb/irqPrioCtrl_tb_top.sv
`timescale 1ns/1ps
module irqPrioCtrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic extPin0N = 1'b1, extPin1N = 1'b1, timerOvf = 1'b0;
  logic ctlWrEn = 1'b0, enWrEn = 1'b0, irqAck = 1'b0, irqRet = 1'b0;
  logic [7:0] ctlWrData = '0;
  logic [3:0] enWrData = '0;
  logic [7:0] ctlRdData;
  logic [3:0] enRdData;
  logic irqReq, idleWake, tmrGate, tmrCntSel, tmrRun;
  logic [9:0] irqVector;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  irqPrioCtrl dut_i (
    .clk(clk), .rst_n(rst_n), .extPin0N(extPin0N), .extPin1N(extPin1N),
    .timerOvf(timerOvf), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .ctlRdData(ctlRdData), .enWrEn(enWrEn), .enWrData(enWrData),
    .enRdData(enRdData), .irqAck(irqAck), .irqRet(irqRet), .irqReq(irqReq),
    .irqVector(irqVector), .idleWake(idleWake), .tmrGate(tmrGate),
    .tmrCntSel(tmrCntSel), .tmrRun(tmrRun)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wrCtl(input logic [7:0] d);
    ctlWrData = d; ctlWrEn = 1'b1; tick(1); ctlWrEn = 1'b0;
  endtask

  task automatic wrEn(input logic [3:0] d);
    enWrData = d; enWrEn = 1'b1; tick(1); enWrEn = 1'b0;
  endtask

  task automatic pulseRet();
    irqRet = 1'b1; tick(1); irqRet = 1'b0;
  endtask

  // flags ordered {pin1, timer, pin0}; returns {req, vector}
  function automatic logic [10:0] model(input logic [2:0] fl, input logic [3:0] en);
    logic [2:0] act;
    act = en[3] ? (fl & en[2:0]) : 3'b000;
    if (act[0])      return {1'b1, 10'h003};
    else if (act[1]) return {1'b1, 10'h00B};
    else if (act[2]) return {1'b1, 10'h013};
    return 11'h0;
  endfunction

  initial begin
    tick(200000);
    fails++;
    $display("FAIL watchdog: actual 0x1 expected 0x0");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [10:0] e;
    logic [2:0] fl;
    logic [3:0] en;
    void'($urandom(32'h1A2B));
    tick(3);
    // R1 reset state
    chk("R1 ctl", ctlRdData, 8'h00);
    chk("R1 en", enRdData, 4'h0);
    chk("R1 req", irqReq, 0);
    chk("R1 vec", irqVector, 0);
    chk("R1 wake", idleWake, 0);
    rst_n = 1'b1;
    tick(1);

    // R2 layout and timer config outputs (both pins in edge mode)
    wrCtl(8'hD5);
    chk("R2 readback", ctlRdData, 8'hD5);
    chk("R2 gate", tmrGate, 1);
    chk("R2 csel", tmrCntSel, 1);
    chk("R2 run", tmrRun, 1);
    wrCtl(8'h05);
    chk("R2 run off", tmrRun, 0);

    // R3 edge detection on pin 0
    extPin0N = 1'b0;
    tick(2);
    chk("R3 flag before latency", ctlRdData[3], 0);
    tick(1);
    chk("R3 falling edge sets", ctlRdData[3], 1);
    wrCtl(8'h05);
    chk("R3 software clear", ctlRdData[3], 0);
    extPin0N = 1'b1;
    tick(5);
    chk("R3 rising edge ignored", ctlRdData[3], 0);
    extPin1N = 1'b0;
    tick(4);
    chk("R3 pin1 edge", ctlRdData[1], 1);
    extPin1N = 1'b1;
    wrCtl(8'h05);

    // R4 level mode on pin 0
    wrCtl(8'h01);
    tick(4);
    chk("R4 level high pin", ctlRdData[3], 0);
    wrCtl(8'h09);
    chk("R4 write ignored", ctlRdData[3], 0);
    extPin0N = 1'b0;
    tick(4);
    chk("R4 level low pin", ctlRdData[3], 1);
    wrCtl(8'h01);
    chk("R4 clear write ignored", ctlRdData[3], 1);

    // R8/R9 acknowledge with level source: flag survives
    wrEn(4'h9);
    chk("R7 level vector", irqVector, 10'h003);
    irqAck = 1'b1; tick(1); irqAck = 1'b0;
    chk("R9 no req in service", irqReq, 0);
    chk("R8 level flag kept", ctlRdData[3], 1);
    chk("R10 wake in service", idleWake, 1);
    tick(3);
    chk("R9 still quiet", irqReq, 0);
    pulseRet();
    chk("R9 resumes after return", irqReq, 1);
    extPin0N = 1'b1;
    tick(4);
    chk("R4 level released", ctlRdData[3], 0);

    // R5 timer pulse
    wrCtl(8'h05);
    timerOvf = 1'b1; tick(1); timerOvf = 1'b0;
    chk("R5 tf set", ctlRdData[5], 1);
    // R6 gating
    wrEn(4'h2);
    chk("R6 global off", irqReq, 0);
    chk("R10 wake global off", idleWake, 0);
    wrEn(4'h9);
    chk("R6 source off", irqReq, 0);
    wrEn(4'hA);
    chk("R6 all on", irqReq, 1);
    chk("R7 timer vector", irqVector, 10'h00B);
    irqAck = 1'b1; tick(1); irqAck = 1'b0;
    chk("R8 tf cleared", ctlRdData[5], 0);
    pulseRet();

    // random patterns, edge mode, flags set by software
    for (int it = 0; it < 300; it++) begin
      fl = 3'($urandom);
      en = 4'($urandom);
      wrEn(en);
      wrCtl({2'b00, fl[1], 1'b0, fl[0], 1'b1, fl[2], 1'b1});
      e = model(fl, en);
      chk("R7 random req", irqReq, e[10]);
      chk("R7 random vec", irqVector, e[9:0]);
      chk("R10 random wake", idleWake, e[10]);
      if (e[10] && ($urandom % 2 == 1)) begin
        irqAck = 1'b1; tick(1); irqAck = 1'b0;
        if (e[9:0] == 10'h003) fl[0] = 1'b0;
        else if (e[9:0] == 10'h00B) fl[1] = 1'b0;
        else fl[2] = 1'b0;
        chk("R8 random clear", {ctlRdData[1], ctlRdData[5], ctlRdData[3]}, fl);
        chk("R9 random quiet", irqReq, 0);
        pulseRet();
        e = model(fl, en);
        chk("R9 random resume", irqVector, e[9:0]);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule